// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block arbitrates interrupt requests for an 8-bit processor with a 16-bit address space. It keeps seventeen vector slots. Slot 0 is the reset slot and slot 16 is the software break slot. Slots 1 to 15 are maskable hardware slots. A lower slot index means a higher priority. Each slot has a two-byte vector in the top page of memory, and the addresses drop by two for each step down in priority.

Requests come from three kinds of source. The first is a set of external pins, each with an edge detector whose active edge is chosen per pin. The second is a wake-up detector that fires when the AND of an 8-bit port's levels falls. The third is a set of single-cycle event pulses from on-chip peripherals. Several maskable slots can take either of two sources, and a per-slot select bit picks one. Latched requests are gated by per-slot enables and a global disable flag. On every cycle the controller presents the highest-priority eligible slot. When the processor acknowledges, it clears that request and drives the low and then the high vector fetch address on two consecutive cycles, holding the result steady while it does.

Top module: `prio_vec_intc`

## Requirements
- R1: When reset is released, only slot 0 is pending. Within two clock cycles `irq_valid`=1, `irq_slot`=0, `vec_lo`=0xFFFC and `vec_hi`=0xFFFD, and `fetch_valid`=0.
- R2: For slot s, `vec_lo` = 0xFFFC − 2·s and `vec_hi` = `vec_lo` + 1. Slot 16 therefore uses 0xFFDC/0xFFDD.
- R3: When more than one slot is eligible, `irq_slot` shows the lowest eligible index.
- R4: Maskable slot m (1..15) is eligible only while `slot_en[m-1]`=1. A request that arrives while the slot is disabled stays latched and appears once the slot is enabled.
- R5: While `glob_dis`=1, none of slots 1..15 is presented. Slots 0 and 16 are not affected.
- R6: A one-cycle `brk_req` pulse sets slot 16. Neither `slot_en` nor `glob_dis` masks it.
- R7: Pin k latches a request when its synchronized level changes to the value of `pin_rise[k]` (1 = rising edge, 0 = falling edge). The slot appears on `irq_valid` within 4 cycles. A change in the other direction sets nothing.
- R8: Changing `pin_rise` while a pin is steady creates no request.
- R9: The wake-up source fires when the AND of all eight `key_port` bits goes from 1 to 0. A rising AND fires nothing.
- R10: Source map, given as slot: A / B, where `src_sel[m-1]`=1 selects B. Pins are p0..p5, hw events are h0..h9, and K is the wake-up source. 1:p0/p0, 2:h0/h0, 3:p1/p1, 4:h1/h1, 5:h2/h2, 6:h3/p5, 7:h4/h4, 8:h5/h5, 9:h6/h6, 10:h7/h7, 11:p3/p5, 12:p4/K, 13:h8/h9, 14:p2/p2, 15:h9/K. The unselected source of a slot sets nothing.
- R11: `ack` while `irq_valid`=1 clears the presented slot's request. On the next cycle `fetch_valid`=1 and `fetch_addr`=`vec_lo`. On the cycle after that, `fetch_addr`=`vec_hi`. Then `fetch_valid` returns to 0. `irq_valid` is 0 and `irq_slot` is frozen during both fetch cycles.
- R12: A cycle with `clr_we`=1 clears every pending slot whose `clr_mask` bit is 1. A source event in that same cycle wins over the clear.
- R13: `ack` while `irq_valid`=0 has no effect: `fetch_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 6 | External pin levels (asynchronous) |
| pin_rise | input | 6 | Per-pin active edge, 1 = rising |
| key_port | input | 8 | Port levels for wake-up AND detector |
| hw_evt | input | 10 | Single-cycle peripheral event pulses |
| brk_req | input | 1 | Break instruction pulse |
| slot_en | input | 15 | Enable for slots 1..15 (bit m-1) |
| glob_dis | input | 1 | Global maskable-interrupt disable |
| src_sel | input | 15 | Source select for slots 1..15, 1 = source B |
| clr_we | input | 1 | Software clear strobe |
| clr_mask | input | 17 | Slots to clear when `clr_we` is 1 |
| ack | input | 1 | Processor accepts the presented slot |
| irq_valid | output | 1 | An eligible slot is presented |
| irq_slot | output | 5 | Presented slot index |
| vec_lo | output | 16 | Low-byte vector address of `irq_slot` |
| vec_hi | output | 16 | High-byte vector address of `irq_slot` |
| fetch_valid | output | 1 | Vector fetch in progress |
| fetch_addr | output | 16 | Current fetch address (low, then high) |

## Verification
The assertions assume that `hw_evt` and `brk_req` are pulses one cycle wide, and that `ack` is a pulse given only where the controller can take it. The single-pulse check on pin events also assumes each pin stays steady for at least one clock after it changes. The stimulus follows these assumptions. It drives every input at the falling clock edge and raises each event line for exactly one cycle. It holds a pin or port level for many cycles after every change. Before each vector it clears all pending slots with the software strobe, so no request is left over from an earlier vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSLOT  = 17;
  localparam int NMSK   = NSLOT - 2;
  localparam int NPIN   = 6;
  localparam int NHW    = 10;
  localparam int NEV    = NPIN + 1 + NHW;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int BRK_SLOT = NSLOT - 1;
  localparam int KEY_EV = NPIN;
  localparam logic [15:0] VEC_TOP = 16'hFFFC;

  typedef enum logic [1:0] {ST_IDLE, ST_FLO, ST_FHI} fetch_st_t;

  // Event-vector index helpers: pins, then wake-up, then peripheral pulses.
  function automatic int pin_ev(input int k);
    return k;
  endfunction
  function automatic int hw_ev(input int k);
    return NPIN + 1 + k;
  endfunction

  // Source routing for maskable slot m; use_b selects the alternate source.
  function automatic int src_idx(input int m, input bit use_b);
    int a, b;
    case (m)
      1:  begin a = pin_ev(0); b = pin_ev(0); end
      2:  begin a = hw_ev(0);  b = hw_ev(0);  end
      3:  begin a = pin_ev(1); b = pin_ev(1); end
      4:  begin a = hw_ev(1);  b = hw_ev(1);  end
      5:  begin a = hw_ev(2);  b = hw_ev(2);  end
      6:  begin a = hw_ev(3);  b = pin_ev(5); end
      7:  begin a = hw_ev(4);  b = hw_ev(4);  end
      8:  begin a = hw_ev(5);  b = hw_ev(5);  end
      9:  begin a = hw_ev(6);  b = hw_ev(6);  end
      10: begin a = hw_ev(7);  b = hw_ev(7);  end
      11: begin a = pin_ev(3); b = pin_ev(5); end
      12: begin a = pin_ev(4); b = KEY_EV;    end
      13: begin a = hw_ev(8);  b = hw_ev(9);  end
      14: begin a = pin_ev(2); b = pin_ev(2); end
      default: begin a = hw_ev(9); b = KEY_EV; end
    endcase
    return use_b ? b : a;
  endfunction

  function automatic logic [15:0] vec_lo_addr(input logic [SLOT_W-1:0] s);
    return VEC_TOP - {{(15-SLOT_W){1'b0}}, s, 1'b0};
  endfunction

  function automatic logic [15:0] vec_hi_addr(input logic [SLOT_W-1:0] s);
    return vec_lo_addr(s) + 16'd1;
  endfunction

  // Lowest set index wins (index 0 = highest priority).
  function automatic logic [SLOT_W-1:0] first_set(input logic [NSLOT-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic evt
);
  logic s1, s2, prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      prev <= 1'b0;
    end else begin
      s1   <= lvl;
      s2   <= s1;
      prev <= s2;
    end
  end

  // Event only on a transition whose new level equals the chosen edge.
  assign evt = (s2 ^ prev) & (s2 == rise_sel);

  // R8: a steady synchronized level never yields an event, whatever rise_sel does
  p_quiet_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(s2) |-> !evt);

  // R7: an edge event lasts a single cycle
  p_single_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/intc_src_route.sv
module intc_src_route
  import intc_pkg::*;
(
  input  logic [NEV-1:0]  ev,
  input  logic [NMSK-1:0] src_sel,
  output logic [NMSK-1:0] msk_set
);
  for (genvar m = 1; m <= NMSK; m++) begin : g_slot
    localparam int IA = src_idx(m, 1'b0);
    localparam int IB = src_idx(m, 1'b1);
    assign msk_set[m-1] = src_sel[m-1] ? ev[IB] : ev[IA];
  end
endmodule

// File: rtl/intc_req_bank.sv
module intc_req_bank
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  set_vec,
  input  logic              ack_take,
  input  logic [SLOT_W-1:0] ack_slot,
  input  logic              clr_we,
  input  logic [NSLOT-1:0]  clr_mask,
  output logic [NSLOT-1:0]  pend
);
  logic [NSLOT-1:0] ack_clr, sw_clr;

  assign ack_clr = ack_take ? (NSLOT'(1) << ack_slot) : '0;
  assign sw_clr  = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= NSLOT'(1);
    else        pend <= (pend & ~(ack_clr | sw_clr)) | set_vec;
  end

  // R11: the accepted slot is cleared unless a new event lands on it
  p_ack_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !set_vec[ack_slot]) |=> !pend[$past(ack_slot)]);

  // R12: software clear drops every masked slot that had no new event
  p_sw_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(clr_mask & ~set_vec)) == '0));

  // R6: a break pulse always latches the break slot
  p_brk_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[BRK_SLOT] |=> pend[BRK_SLOT]);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  pend,
  input  logic [NMSK-1:0]   slot_en,
  input  logic              glob_dis,
  input  logic              ack,
  output logic              irq_valid,
  output logic [SLOT_W-1:0] irq_slot,
  output logic [15:0]       vec_lo,
  output logic [15:0]       vec_hi,
  output logic              fetch_valid,
  output logic [15:0]       fetch_addr,
  output logic              ack_take
);
  logic [NSLOT-1:0]  elig;
  logic              win_any;
  logic [SLOT_W-1:0] win_slot;
  logic              valid_q;
  logic [SLOT_W-1:0] slot_q;
  logic              sample;
  fetch_st_t         st;

  assign elig[0]        = pend[0];
  assign elig[BRK_SLOT] = pend[BRK_SLOT];
  for (genvar m = 1; m <= NMSK; m++) begin : g_gate
    assign elig[m] = pend[m] & slot_en[m-1] & ~glob_dis;
  end

  assign win_any  = |elig;
  assign win_slot = first_set(elig);

  assign irq_valid = valid_q && (st == ST_IDLE);
  assign ack_take  = ack && irq_valid;
  // Sampling point: idle cycles without an accept, and the final fetch cycle.
  assign sample    = ((st == ST_IDLE) && !ack_take) || (st == ST_FHI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      valid_q <= 1'b0;
      slot_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (ack_take) st <= ST_FLO;
        ST_FLO:  st <= ST_FHI;
        default: st <= ST_IDLE;
      endcase
      if (sample) begin
        valid_q <= win_any;
        slot_q  <= win_slot;
      end
    end
  end

  assign irq_slot    = slot_q;
  assign vec_lo      = vec_lo_addr(slot_q);
  assign vec_hi      = vec_hi_addr(slot_q);
  assign fetch_valid = (st != ST_IDLE);
  assign fetch_addr  = (st == ST_FHI) ? vec_hi : (st == ST_FLO) ? vec_lo : 16'h0000;

  // R4 / R5: a maskable winner must be enabled and not globally disabled
  p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_any && win_slot != '0 && win_slot != SLOT_W'(BRK_SLOT))
      |-> (slot_en[win_slot - SLOT_W'(1)] && !glob_dis));

  // R3: no eligible slot above the chosen winner
  p_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |-> ((elig & ((NSLOT'(1) << win_slot) - NSLOT'(1))) == '0));

  // R11: slot frozen across the low-byte fetch cycle
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FLO) |=> $stable(irq_slot));

  // R2: the second fetch address is one above the first
  p_fetch_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid)) |-> (fetch_addr == $past(fetch_addr) + 16'd1));

  // R13: no fetch starts without a presented slot
  p_no_idle_fetch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !irq_valid) |=> !fetch_valid);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic [NPIN-1:0]   pin_rise,
  input  logic [7:0]        key_port,
  input  logic [NHW-1:0]    hw_evt,
  input  logic              brk_req,
  input  logic [NMSK-1:0]   slot_en,
  input  logic              glob_dis,
  input  logic [NMSK-1:0]   src_sel,
  input  logic              clr_we,
  input  logic [NSLOT-1:0]  clr_mask,
  input  logic              ack,
  output logic              irq_valid,
  output logic [SLOT_W-1:0] irq_slot,
  output logic [15:0]       vec_lo,
  output logic [15:0]       vec_hi,
  output logic              fetch_valid,
  output logic [15:0]       fetch_addr
);
  logic [NPIN-1:0]   pin_evt;
  logic              key_evt;
  logic [NEV-1:0]    ev;
  logic [NMSK-1:0]   msk_set;
  logic [NSLOT-1:0]  set_vec;
  logic [NSLOT-1:0]  pend;
  logic              ack_take;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    intc_edge_det u_det (
      .clk(clk), .rst_n(rst_n), .lvl(pin_lvl[k]), .rise_sel(pin_rise[k]), .evt(pin_evt[k])
    );
  end

  // Wake-up: falling edge of the port AND, fixed polarity
  intc_edge_det u_key (
    .clk(clk), .rst_n(rst_n), .lvl(&key_port), .rise_sel(1'b0), .evt(key_evt)
  );

  assign ev = {hw_evt, key_evt, pin_evt};

  intc_src_route u_route (.ev(ev), .src_sel(src_sel), .msk_set(msk_set));

  assign set_vec = {brk_req, msk_set, 1'b0};

  intc_req_bank u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .ack_take(ack_take),
    .ack_slot(irq_slot), .clr_we(clr_we), .clr_mask(clr_mask), .pend(pend)
  );

  intc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .slot_en(slot_en), .glob_dis(glob_dis),
    .ack(ack), .irq_valid(irq_valid), .irq_slot(irq_slot), .vec_lo(vec_lo),
    .vec_hi(vec_hi), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .ack_take(ack_take)
  );

  // R1: the reset slot is the only request right after reset
  p_reset_pend_r1: assert property (@(posedge clk)
    (!rst_n) |=> (pend == NSLOT'(1)));
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  pin_lvl, pin_rise;
  logic [7:0]  key_port;
  logic [9:0]  hw_evt;
  logic        brk_req, glob_dis, clr_we, ack;
  logic [14:0] slot_en, src_sel;
  logic [16:0] clr_mask;
  logic        irq_valid, fetch_valid;
  logic [4:0]  irq_slot;
  logic [15:0] vec_lo, vec_hi, fetch_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  prio_vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_rise(pin_rise), .key_port(key_port),
    .hw_evt(hw_evt), .brk_req(brk_req), .slot_en(slot_en), .glob_dis(glob_dis),
    .src_sel(src_sel), .clr_we(clr_we), .clr_mask(clr_mask), .ack(ack),
    .irq_valid(irq_valid), .irq_slot(irq_slot), .vec_lo(vec_lo), .vec_hi(vec_hi),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
  );

  // kind: 0 peripheral pulse, 1 pin toggle, 2 port AND fall, 3 break
  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  idx;
    logic        match;
    logic [14:0] en;
    logic        gdis;
    logic [14:0] sel;
    logic        exp_v;
    logic [4:0]  exp_s;
    logic [3:0]  req;
  } vec_t;

  localparam logic [14:0] ALL = 15'h7FFF;
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'd0, 4'd0, 1'b1, ALL,      1'b0, 15'h0000, 1'b1, 5'd2,  4'd10}, // R10 h0 -> 2
    '{2'd0, 4'd4, 1'b1, ALL,      1'b0, 15'h0000, 1'b1, 5'd7,  4'd10}, // R10 h4 -> 7
    '{2'd1, 4'd0, 1'b1, ALL,      1'b0, 15'h0000, 1'b1, 5'd1,  4'd7},  // R7 matching edge
    '{2'd1, 4'd0, 1'b0, ALL,      1'b0, 15'h0000, 1'b0, 5'd0,  4'd7},  // R7 other edge
    '{2'd1, 4'd1, 1'b1, 15'h7FFB, 1'b0, 15'h0000, 1'b0, 5'd0,  4'd4},  // R4 slot 3 off
    '{2'd0, 4'd2, 1'b1, ALL,      1'b1, 15'h0000, 1'b0, 5'd0,  4'd5},  // R5 global off
    '{2'd3, 4'd0, 1'b1, 15'h0000, 1'b1, 15'h0000, 1'b1, 5'd16, 4'd6},  // R6 break unmaskable
    '{2'd1, 4'd5, 1'b1, ALL,      1'b0, 15'h0020, 1'b1, 5'd6,  4'd10}, // R10 p5 via B of 6
    '{2'd1, 4'd5, 1'b1, ALL,      1'b0, 15'h0000, 1'b0, 5'd0,  4'd10}, // R10 p5 unselected
    '{2'd2, 4'd0, 1'b1, ALL,      1'b0, 15'h0800, 1'b1, 5'd12, 4'd9},  // R9 K via 12
    '{2'd2, 4'd0, 1'b1, ALL,      1'b0, 15'h4000, 1'b1, 5'd15, 4'd9},  // R9 K via 15
    '{2'd0, 4'd9, 1'b1, ALL,      1'b0, 15'h1000, 1'b1, 5'd13, 4'd3},  // R3 13 beats 15
    '{2'd0, 4'd3, 1'b1, ALL,      1'b0, 15'h0020, 1'b0, 5'd0,  4'd10}, // R10 h3 unselected
    '{2'd1, 4'd3, 1'b1, ALL,      1'b0, 15'h0000, 1'b1, 5'd11, 4'd7}   // R7 p3 -> 11
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic chk(input int r, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0h expected %0h", r, what, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] exp_lo(input int s);
    return 16'hFFFC - 16'(s * 2);
  endfunction

  task automatic clear_all();
    clr_mask = '1; clr_we = 1'b1;
    cyc(1);
    clr_we = 1'b0; clr_mask = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin_lvl = '0; pin_rise = '1; key_port = '0; hw_evt = '0;
    brk_req = 1'b0; slot_en = ALL; glob_dis = 1'b0; src_sel = '0;
    clr_we = 1'b0; clr_mask = '0; ack = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset slot presented
    chk(1, "irq_valid after reset", 32'(irq_valid), 32'd1);
    chk(1, "irq_slot after reset", 32'(irq_slot), 32'd0);
    chk(1, "vec_lo after reset", 32'(vec_lo), 32'hFFFC);
    chk(1, "vec_hi after reset", 32'(vec_hi), 32'hFFFD);
    chk(1, "fetch_valid after reset", 32'(fetch_valid), 32'd0);

    // R11 acknowledge sequence on the reset slot
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk(11, "fetch_valid lo", 32'(fetch_valid), 32'd1);
    chk(11, "fetch_addr lo", 32'(fetch_addr), 32'hFFFC);
    chk(11, "irq_valid in fetch", 32'(irq_valid), 32'd0);
    cyc(1);
    chk(11, "fetch_addr hi", 32'(fetch_addr), 32'hFFFD);
    chk(11, "slot frozen", 32'(irq_slot), 32'd0);
    cyc(1);
    chk(11, "fetch ends", 32'(fetch_valid), 32'd0);
    chk(11, "reset slot cleared", 32'(irq_valid), 32'd0);

    // R13 ack with nothing presented
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk(13, "no fetch on idle ack", 32'(fetch_valid), 32'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      slot_en = VT[i].en; glob_dis = VT[i].gdis; src_sel = VT[i].sel;
      if (VT[i].kind == 2'd1)
        pin_rise[VT[i].idx] = VT[i].match ? ~pin_lvl[VT[i].idx] : pin_lvl[VT[i].idx];
      if (VT[i].kind == 2'd2) key_port = 8'hFF;
      cyc(6);
      clear_all();
      case (VT[i].kind)
        2'd0: begin hw_evt[VT[i].idx] = 1'b1; cyc(1); hw_evt = '0; end
        2'd1: pin_lvl[VT[i].idx] = ~pin_lvl[VT[i].idx];
        2'd2: key_port = 8'hEF;
        default: begin brk_req = 1'b1; cyc(1); brk_req = 1'b0; end
      endcase
      cyc(8);
      chk(int'(VT[i].req), $sformatf("vector %0d valid", i), 32'(irq_valid), 32'(VT[i].exp_v));
      if (VT[i].exp_v) begin
        chk(int'(VT[i].req), $sformatf("vector %0d slot", i), 32'(irq_slot), 32'(VT[i].exp_s));
        chk(2, $sformatf("vector %0d vec_lo", i), 32'(vec_lo), 32'(exp_lo(int'(VT[i].exp_s))));
      end
    end

    // R2 break slot vectors and fetch order
    slot_en = ALL; glob_dis = 1'b0; src_sel = '0;
    clear_all();
    brk_req = 1'b1; cyc(1); brk_req = 1'b0;
    cyc(2);
    chk(2, "brk vec_lo", 32'(vec_lo), 32'hFFDC);
    chk(2, "brk vec_hi", 32'(vec_hi), 32'hFFDD);
    ack = 1'b1; cyc(1); ack = 1'b0;
    chk(2, "brk fetch lo", 32'(fetch_addr), 32'hFFDC);
    cyc(1);
    chk(2, "brk fetch hi", 32'(fetch_addr), 32'hFFDD);
    cyc(2);
    chk(11, "brk cleared by ack", 32'(irq_valid), 32'd0);

    // R8 toggling edge select on a steady pin
    clear_all();
    for (int t = 0; t < 4; t++) begin
      pin_rise[2] = ~pin_rise[2]; cyc(2);
    end
    cyc(6);
    chk(8, "edge select change", 32'(irq_valid), 32'd0);

    // R4 latched while disabled, shown once enabled
    clear_all();
    slot_en = ALL & ~15'h0002;
    hw_evt[0] = 1'b1; cyc(1); hw_evt = '0;
    cyc(6);
    chk(4, "disabled slot hidden", 32'(irq_valid), 32'd0);
    slot_en = ALL; cyc(3);
    chk(4, "retained request shown", 32'(irq_slot), 32'd2);
    chk(4, "retained request valid", 32'(irq_valid), 32'd1);

    // R12 software clear of one slot
    clr_mask = 17'h00004; clr_we = 1'b1; cyc(1); clr_we = 1'b0; clr_mask = '0;
    cyc(3);
    chk(12, "software clear", 32'(irq_valid), 32'd0);

    // R12 set wins over simultaneous clear
    hw_evt[1] = 1'b1; clr_mask = 17'h00010; clr_we = 1'b1;
    cyc(1);
    hw_evt = '0; clr_we = 1'b0; clr_mask = '0;
    cyc(3);
    chk(12, "event beats clear", 32'(irq_slot), 32'd4);
    chk(12, "event beats clear valid", 32'(irq_valid), 32'd1);

    // R5 global disable leaves reset-class slots alone (break still shows)
    glob_dis = 1'b1;
    brk_req = 1'b1; cyc(1); brk_req = 1'b0;
    cyc(3);
    chk(5, "break under global disable", 32'(irq_slot), 32'd16);

    summary();
    $finish;
  end
endmodule